// File: doc/BRIEF.md
# Registered Adder-Subtractor with Magnitude Compare

This block is a small unsigned arithmetic unit. It either adds or subtracts two operands. One mode line picks the operation. When the mode line is high, it inverts every bit of the second operand and also supplies the carry into the lowest bit. The sum then equals the first operand plus the two's complement of the second. A single ripple chain of full-adder cells produces the result and the carry out of the top bit.

The subtract path also serves as a comparator. A zero difference means the operands are equal. The carry out tells whether the first operand is at least the second. Equality and carry together give strict greater-than. A separate comparator is not needed.

The operands are sampled on a clock edge where the strobe is high. The result, the carry and the four flags are registered. They appear one cycle later, together with a one-cycle done pulse. The operand width is a parameter with a default of 4.

Top module: `addsub_cmp`

## Requirements
- R1: With `sub_mode`=0 at the strobe, `res_q` equals (A+B) mod 2^WIDTH and `carry_q` equals bit WIDTH of A+B.
- R2: With `sub_mode`=1 at the strobe, `res_q` equals (A-B) mod 2^WIDTH and `carry_q` equals 1 exactly when A >= B.
- R3: With `sub_mode`=1, `eq_q` is 1 exactly when A equals B, which is when the difference is all zeros.
- R4: With `sub_mode`=1, `ge_q` is 1 when A >= B and `lt_q` is 1 when A < B. Exactly one of the two is set.
- R5: With `sub_mode`=1, `gt_q` is 1 exactly when the carry out is 1 and the difference is non-zero, which is when A > B.
- R6: With `sub_mode`=0, all four flags (`eq_q`, `ge_q`, `lt_q`, `gt_q`) are 0.
- R7: Results sampled on a clock edge where `in_valid`=1 appear after that edge, together with `done_q`=1. Back-to-back strobes update the outputs on every cycle.
- R8: On an edge where `in_valid`=0, `done_q` goes to 0 and `res_q`, `carry_q` and the flags keep their values.
- R9: Synchronous active-high `rst` clears `res_q`, `carry_q`, all flags and `done_q`, even when `in_valid` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| sub_mode | input | 1 | 0 = add, 1 = subtract and compare |
| op_a | input | WIDTH | First operand A |
| op_b | input | WIDTH | Second operand B |
| res_q | output | WIDTH | Registered sum or difference |
| carry_q | output | 1 | Registered carry out of the top bit |
| eq_q | output | 1 | A equals B (subtract mode only) |
| ge_q | output | 1 | A greater than or equal to B (subtract mode only) |
| lt_q | output | 1 | A less than B (subtract mode only) |
| gt_q | output | 1 | A strictly greater than B (subtract mode only) |
| done_q | output | 1 | One-cycle pulse marking fresh outputs |

## Verification
Two things can land in the same cycle: a reset and an operand strobe. The bench raises both together. It then judges that every output is cleared and that `done_q` stays low, so the reset wins.

A second case is an idle cycle that follows a strobe. Here the register capture and the hold behaviour meet. The bench checks that `done_q` falls while the result and flags stay at the last computed values.

Strobes issued back to back are checked one cycle apart. This shows that each new result replaces the previous one with no gap.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic eq;
    logic ge;
    logic lt;
    logic gt;
  } cmp_flags_t;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = x ^ y;
  assign s  = p ^ ci;
  assign co = (x & y) | (ci & p);
endmodule

// File: rtl/ripple_addsub.sv
module ripple_addsub #(
  parameter int WIDTH = 4
) (
  input  logic             sub,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   c;

  assign b_eff = b ^ {WIDTH{sub}};
  assign c[0]  = sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    fa_cell u_fa (
      .x  (a[i]),
      .y  (b_eff[i]),
      .ci (c[i]),
      .s  (sum[i]),
      .co (c[i+1])
    );
  end

  assign cout = c[WIDTH];
endmodule

// File: rtl/flag_derive.sv
module flag_derive
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             sub,
  input  logic [WIDTH-1:0] diff,
  input  logic             cout,
  output cmp_flags_t       flags
);
  logic zero;
  assign zero = (diff == '0);

  always_comb begin
    flags = '0;
    if (sub) begin
      flags.eq = zero;
      flags.ge = cout;
      flags.lt = ~cout;
      flags.gt = cout & ~zero;
    end
  end
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             sub_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] res_q,
  output logic             carry_q,
  output logic             eq_q,
  output logic             ge_q,
  output logic             lt_q,
  output logic             gt_q,
  output logic             done_q
);
  logic [WIDTH-1:0] sum_d;
  logic             cout_d;
  cmp_flags_t       flags_d;
  cmp_flags_t       flags_q;

  ripple_addsub #(.WIDTH(WIDTH)) u_chain (
    .sub  (sub_mode),
    .a    (op_a),
    .b    (op_b),
    .sum  (sum_d),
    .cout (cout_d)
  );

  flag_derive #(.WIDTH(WIDTH)) u_flags (
    .sub   (sub_mode),
    .diff  (sum_d),
    .cout  (cout_d),
    .flags (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= in_valid;
      if (in_valid) begin
        res_q   <= sum_d;
        carry_q <= cout_d;
        flags_q <= flags_d;
      end
    end
  end

  assign eq_q = flags_q.eq;
  assign ge_q = flags_q.ge;
  assign lt_q = flags_q.lt;
  assign gt_q = flags_q.gt;
endmodule

// File: rtl/addsub_cmp_chk.sv
module addsub_cmp_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             sub_mode,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] res_q,
  input logic             carry_q,
  input logic             eq_q,
  input logic             ge_q,
  input logic             lt_q,
  input logic             gt_q,
  input logic             done_q
);
  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub_mode) |=>
      ({carry_q, res_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

  // R2
  sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_mode) |=> (carry_q == ($past(op_a) >= $past(op_b))));

  // R3
  eq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_mode) |=> (eq_q == ($past(op_a) == $past(op_b))));

  // R4
  ge_lt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_mode) |=> (ge_q ^ lt_q));

  // R5
  gt_implies_chk: assert property (@(posedge clk) disable iff (rst)
    gt_q |-> (ge_q && !eq_q && !lt_q));

  // R6
  add_flags_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub_mode) |=> !(eq_q || ge_q || lt_q || gt_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done_q);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!done_q && $stable(res_q) && $stable(carry_q) &&
                   $stable({eq_q, ge_q, lt_q, gt_q})));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done_q && res_q == '0 && !carry_q &&
             !(eq_q || ge_q || lt_q || gt_q)));
endmodule

bind addsub_cmp addsub_cmp_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/tb_addsub_cmp.sv
`timescale 1ns/1ps
module tb_addsub_cmp;
  localparam int W = 4;
  localparam int NV = 11;

  // stimulus {sub_mode, a, b}; expected {carry, res, eq, ge, lt, gt}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0000_0000, 9'b0_1111_0001, 9'b0_1001_0110, 9'b0_1111_1111,
    9'b1_0101_0101, 9'b1_0000_0000, 9'b1_0111_0011, 9'b1_0011_0111,
    9'b1_0000_1111, 9'b1_1111_0000, 9'b0_0101_0101
  };
  localparam logic [8:0] EXPV [NV] = '{
    9'b0_0000_0000, 9'b1_0000_0000, 9'b0_1111_0000, 9'b1_1110_0000,
    9'b1_0000_1100, 9'b1_0000_1100, 9'b1_0100_0101, 9'b0_1100_0010,
    9'b0_0001_0010, 9'b1_1111_0101, 9'b0_1010_0000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic sub_mode = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] res_q;
  logic carry_q, eq_q, ge_q, lt_q, gt_q, done_q;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  addsub_cmp #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sub_mode(sub_mode),
    .op_a(op_a), .op_b(op_b), .res_q(res_q), .carry_q(carry_q),
    .eq_q(eq_q), .ge_q(ge_q), .lt_q(lt_q), .gt_q(gt_q), .done_q(done_q)
  );

  function automatic logic [8:0] model(input logic m, input int a, input int b);
    int t;
    logic [8:0] r;
    if (m) t = a - b + 16; else t = a + b;
    r[8]   = (t >= 16);
    r[7:4] = 4'(t % 16);
    r[3]   = m && (a == b);
    r[2]   = m && (a >= b);
    r[1]   = m && (a < b);
    r[0]   = m && (a > b);
    return r;
  endfunction

  function automatic logic [8:0] outs();
    return {carry_q, res_q, eq_q, ge_q, lt_q, gt_q};
  endfunction

  task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    sub_mode = m; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [8:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 reset state", {done_q, outs()}, 10'b0);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][8], VEC[i][7:4], VEC[i][3:0]);
      check("R1/R2/R3/R4/R5/R6 table", {done_q, outs()}, {1'b1, EXPV[i]});
    end

    // exhaustive sweep against the arithmetic model
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          apply(m[0], 4'(a), 4'(b));
          check(m ? "R2/R3/R4/R5 sweep" : "R1/R6 sweep",
                {done_q, outs()}, {1'b1, model(m[0], a, b)});
        end

    // R8: idle cycles hold outputs, done low
    apply(1'b1, 4'd3, 4'd9);
    held = outs();
    @(negedge clk);
    op_a = 4'd15; op_b = 4'd0; sub_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 idle hold", {done_q, outs()}, {1'b0, held});

    // R7: back-to-back strobes
    @(negedge clk);
    sub_mode = 1'b0; op_a = 4'd2; op_b = 4'd3; in_valid = 1'b1;
    @(negedge clk);
    check("R7 first of pair", {done_q, outs()}, {1'b1, model(1'b0, 2, 3)});
    sub_mode = 1'b1; op_a = 4'd12; op_b = 4'd12;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second of pair", {done_q, outs()}, {1'b1, model(1'b1, 12, 12)});

    // R9: reset together with a strobe
    apply(1'b1, 4'd15, 4'd1);
    @(negedge clk);
    sub_mode = 1'b1; op_a = 4'd9; op_b = 4'd2; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check("R9 reset beats strobe", {done_q, outs()}, 10'b0);

    finish_run();
  end
endmodule